// File: doc/BRIEF.md
# Real Power Computation Datapath

This block turns a pair of signed sample streams, one from the load-current sensor and one from the line-voltage sensor, into a signed real-power stream. The current samples pass through a first-order high-pass stage that tracks and subtracts their DC level. The cleaned current is then multiplied by the voltage sample of the same instant to form instantaneous power. A first-order low-pass stage smooths that product so that its mean, the real power, remains. Some ripple at twice the line frequency is deliberately left in, because the pulse converters that follow average it out.

The voltage path is not high-pass filtered. Removing DC from one factor is enough to stop any offset cross-term from reaching the mean of the product. The two channels have different analogue full scales, and each sample width is set so that its own channel's full scale maps to the full-scale code.

Samples arrive with a valid strobe, at most one per cycle. Each accepted pair yields exactly one output result a fixed number of cycles later. Both filters use shift-and-add arithmetic with shift amounts set by parameters, and every state register saturates at the limits of its range.

Top module: `rpwr_datapath`

## Requirements
- R1: While `rst_n` is low at a clock edge, both filter states and all pipeline registers are cleared, so that `out_vld` is 0 and `pwr_out` is 0 after that edge.
- R2: Each cycle with `in_vld` high yields exactly one cycle with `out_vld` high, three clock edges later, counting the edge that captures the inputs. Results leave in the order in which the samples arrived.
- R3: The current high-pass stage keeps a signed state of IW+HPF_SH+2 bits. Its estimate is the floor of state/2^HPF_SH, clamped to IW bits. The difference is the current sample minus that estimate. The filtered current is the difference clamped to the signed IW-bit range. The new state is the state plus the unclamped difference, clamped to the state's range.
- R4: Instantaneous power is the full 2*IW-bit signed product of the filtered current and the voltage sample of the same pair.
- R5: The low-pass stage keeps a signed state of 2*IW+LPF_SH+2 bits. On each product it adds the product and subtracts floor(state/2^LPF_SH), then clamps the result to its range. The filter output is floor(new state/2^LPF_SH), clamped to 2*IW bits.
- R6: `pwr_out` is the filter output of R5 divided by 2^(2*IW-OW) and rounded towards minus infinity, which is its upper OW bits in two's complement.
- R7: In a cycle with `in_vld` low, no filter state changes, `out_vld` stays low three edges later, and `pwr_out` keeps its last value.
- R8: When both inputs are held at constant DC values, `pwr_out` settles to exactly 0.
- R9: When current and voltage are sinusoids in phase, the settled `pwr_out` is positive. When they are in antiphase, it is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | A sample pair is present this cycle |
| cur_in | input | IW | Signed current-channel sample |
| volt_in | input | IW | Signed voltage-channel sample |
| out_vld | output | 1 | `pwr_out` carries a new result this cycle |
| pwr_out | output | OW | Signed filtered real power, held between results |

## Verification
A result becomes visible after the third rising edge that follows the negedge at which the bench drives the sample pair. The driver stamps every expected value with the cycle count at drive time. When `out_vld` is seen at a negedge, the monitor pops the oldest entry, compares the value, and requires a distance of exactly three cycles. In every negedge without `out_vld`, the monitor requires `pwr_out` to be unchanged. The DC and sinusoid scenarios run for tens of thousands of samples and are judged only after the pipeline has been drained.

// File: rtl/rpwr_pkg.sv
// Shared helpers for the real power datapath.
// Assumes every width handed to clamp64 lies between 2 and 63.
package rpwr_pkg;

    typedef logic signed [63:0] wide_t;

    // Saturate a wide signed value to the signed range of w bits.
    function automatic wide_t clamp64(input wide_t v, input int w);
        wide_t hi;
        wide_t lo;
        hi = (64'sd1 <<< (w - 1)) - 64'sd1;
        lo = -(64'sd1 <<< (w - 1));
        if (v > hi)
            return hi;
        else if (v < lo)
            return lo;
        else
            return v;
    endfunction

endpackage

// File: rtl/rpwr_hpf.sv
// First-order DC-tracking high-pass stage for the current channel.
// The state follows the input DC with a time constant of 2^HS samples,
// and the output is the input minus the tracked DC, saturated to IW bits.
// Assumes at most one sample per cycle; the output is registered.
module rpwr_hpf #(
    parameter int IW = 16,
    parameter int HS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic signed [IW-1:0] x_in,
    output logic                 y_vld,
    output logic signed [IW-1:0] y_out,
    output logic signed [IW-1:0] dc_est
);
    import rpwr_pkg::*;

    localparam int DW = IW + HS + 2;

    logic signed [DW-1:0] acc;
    logic signed [IW:0]   diff;
    logic signed [IW-1:0] y_nxt;
    logic signed [DW-1:0] acc_nxt;

    // Estimate, difference and next state for the present sample.
    always_comb begin
        dc_est  = IW'(clamp64(64'(acc) >>> HS, IW));
        diff    = (IW+1)'(x_in) - (IW+1)'(dc_est);
        y_nxt   = IW'(clamp64(64'(diff), IW));
        acc_nxt = DW'(clamp64(64'(acc) + 64'(diff), DW));
    end

    // Update the DC state and the output register on accepted samples only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            y_out <= '0;
            y_vld <= 1'b0;
        end else begin
            y_vld <= in_vld;
            if (in_vld) begin
                acc   <= acc_nxt;
                y_out <= y_nxt;
            end
        end
    end

endmodule

// File: rtl/rpwr_mul.sv
// Registered signed multiplier forming instantaneous power.
// Assumes both operands are IW-bit signed; the 2*IW-bit product is exact.
module rpwr_mul #(
    parameter int IW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_vld,
    input  logic signed [IW-1:0]   a_in,
    input  logic signed [IW-1:0]   b_in,
    output logic                   p_vld,
    output logic signed [2*IW-1:0] p_out
);
    localparam int PW = 2 * IW;

    logic signed [PW-1:0] prod;

    // Full-precision product of the aligned operands.
    always_comb prod = PW'(a_in) * PW'(b_in);

    // Capture the product on valid samples only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_out <= '0;
            p_vld <= 1'b0;
        end else begin
            p_vld <= in_vld;
            if (in_vld)
                p_out <= prod;
        end
    end

endmodule

// File: rtl/rpwr_lpf.sv
// First-order low-pass stage that extracts the mean of the power product,
// followed by truncation of the result to OW bits.
// Assumes PW+LS+2 stays below 64 and OW does not exceed PW.
module rpwr_lpf #(
    parameter int PW = 32,
    parameter int LS = 10,
    parameter int OW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic signed [PW-1:0] p_in,
    output logic                 out_vld,
    output logic signed [OW-1:0] pwr_out
);
    import rpwr_pkg::*;

    localparam int AW   = PW + LS + 2;
    localparam int DROP = PW - OW;

    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] acc_nxt;
    logic signed [PW-1:0] y_nxt;

    // Leaky accumulation, then the scaled and saturated filter output.
    always_comb begin
        acc_nxt = AW'(clamp64(64'(acc) + 64'(p_in) - (64'(acc) >>> LS), AW));
        y_nxt   = PW'(clamp64(64'(acc_nxt) >>> LS, PW));
    end

    // Advance the filter and refresh the output on valid products only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            pwr_out <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                acc     <= acc_nxt;
                pwr_out <= OW'(y_nxt >>> DROP);
            end
        end
    end

endmodule

// File: rtl/rpwr_datapath.sv
// Real power datapath: current high-pass, multiply by voltage, low-pass.
// Three register stages; the voltage sample is delayed one stage so that it
// meets the filtered current of the same pair. Assumes at most one pair
// per cycle, framed by in_vld.
module rpwr_datapath #(
    parameter int IW     = 16,
    parameter int HPF_SH = 8,
    parameter int LPF_SH = 10,
    parameter int OW     = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic signed [IW-1:0] cur_in,
    input  logic signed [IW-1:0] volt_in,
    output logic                 out_vld,
    output logic signed [OW-1:0] pwr_out
);
    localparam int PW = 2 * IW;

    logic                 s1_vld;
    logic signed [IW-1:0] hcur;
    logic signed [IW-1:0] dc_est;
    logic signed [IW-1:0] v_d;
    logic                 s2_vld;
    logic signed [PW-1:0] prod;

    rpwr_hpf #(.IW(IW), .HS(HPF_SH)) u_hpf (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (in_vld),
        .x_in   (cur_in),
        .y_vld  (s1_vld),
        .y_out  (hcur),
        .dc_est (dc_est)
    );

    // Delay the voltage sample to line up with the filtered current.
    always_ff @(posedge clk) begin
        if (!rst_n)
            v_d <= '0;
        else if (in_vld)
            v_d <= volt_in;
    end

    rpwr_mul #(.IW(IW)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (s1_vld),
        .a_in   (hcur),
        .b_in   (v_d),
        .p_vld  (s2_vld),
        .p_out  (prod)
    );

    rpwr_lpf #(.PW(PW), .LS(LPF_SH), .OW(OW)) u_lpf (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (s2_vld),
        .p_in    (prod),
        .out_vld (out_vld),
        .pwr_out (pwr_out)
    );

endmodule

// File: rtl/rpwr_datapath_chk.sv
// Property checker for rpwr_datapath, attached through bind.
// Observes the ports and the stage boundaries of the datapath.
module rpwr_datapath_chk #(
    parameter int IW = 16,
    parameter int OW = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_vld,
    input logic signed [IW-1:0] cur_in,
    input logic                 s1_vld,
    input logic signed [IW-1:0] hcur,
    input logic signed [IW-1:0] dc_est,
    input logic                 out_vld,
    input logic signed [OW-1:0] pwr_out
);

    // R2: every accepted pair produces a result three edges later
    p_latency_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> ##3 out_vld);

    // R2: no result appears without a pair three edges earlier
    p_latency_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(in_vld, 3));

    // R7: the output holds its value between results
    p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> $stable(pwr_out));

    // R7: the high-pass state does not move without a sample
    p_dc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(dc_est));

    // R3: a sample equal to the tracked DC leaves zero filtered current
    p_dc_cancel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && cur_in == dc_est) |=> (s1_vld && hcur == '0));

endmodule

bind rpwr_datapath rpwr_datapath_chk #(.IW(IW), .OW(OW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .cur_in  (cur_in),
    .s1_vld  (s1_vld),
    .hcur    (hcur),
    .dc_est  (dc_est),
    .out_vld (out_vld),
    .pwr_out (pwr_out)
);

// File: tb/rpwr_datapath_tb.sv
// Scoreboard bench: the driver computes each expected result from the
// requirement equations and queues it; the monitor pops and compares.
module rpwr_datapath_tb;

    localparam int IW     = 16;
    localparam int HPF_SH = 8;
    localparam int LPF_SH = 10;
    localparam int OW     = 24;
    localparam int PW     = 2 * IW;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_vld = 1'b0;
    logic signed [IW-1:0] cur_in = '0;
    logic signed [IW-1:0] volt_in = '0;
    logic                 out_vld;
    logic signed [OW-1:0] pwr_out;

    int     n_chk = 0;
    int     n_bad = 0;
    longint cyc = 0;
    string  tag = "R2";

    longint exp_q[$];
    longint cyc_q[$];
    longint last_out = 0;

    // Requirement-level model state.
    longint m_dc = 0;
    longint m_lp = 0;

    rpwr_datapath #(.IW(IW), .HPF_SH(HPF_SH), .LPF_SH(LPF_SH), .OW(OW)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .cur_in  (cur_in),
        .volt_in (volt_in),
        .out_vld (out_vld),
        .pwr_out (pwr_out)
    );

    initial forever #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint clampw(input longint v, input int w);
        longint hi;
        longint lo;
        hi = (64'sd1 <<< (w - 1)) - 1;
        lo = -(64'sd1 <<< (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // R3, R4, R5, R6 as equations on the model state.
    function automatic longint model_step(input longint c, input longint v);
        longint est, diff, hy, p, y;
        est  = clampw(m_dc >>> HPF_SH, IW);
        diff = c - est;
        hy   = clampw(diff, IW);
        m_dc = clampw(m_dc + diff, IW + HPF_SH + 2);
        p    = hy * v;
        m_lp = clampw(m_lp + p - (m_lp >>> LPF_SH), PW + LPF_SH + 2);
        y    = clampw(m_lp >>> LPF_SH, PW);
        return y >>> (PW - OW);
    endfunction

    task automatic check(input bit ok, input string rq, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
        end
    endtask

    task automatic send(input int c, input int v);
        @(negedge clk);
        cur_in  = IW'(c);
        volt_in = IW'(v);
        in_vld  = 1'b1;
        exp_q.push_back(model_step(c, v));
        cyc_q.push_back(cyc);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
        end
    endtask

    task automatic do_reset();
        idle(6);
        @(negedge clk);
        rst_n = 1'b0;
        m_dc = 0;
        m_lp = 0;
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: cleared state straight after reset
        check(out_vld == 1'b0 && pwr_out == '0, "R1 reset state", longint'(pwr_out), 0);
    endtask

    // Monitor: compare results, latency and holding between results.
    always @(negedge clk) begin
        if (!rst_n) begin
            last_out = 0;
        end else if (out_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected result", longint'(pwr_out), 0);
            end else begin
                longint e, c0;
                e  = exp_q.pop_front();
                c0 = cyc_q.pop_front();
                check(cyc - c0 == 3, "R2 latency", cyc - c0, 3);
                check(longint'(pwr_out) == e, tag, longint'(pwr_out), e);
            end
            last_out = longint'(pwr_out);
        end else begin
            // R7: output held while no result is due
            check(longint'(pwr_out) == last_out, "R7 hold", longint'(pwr_out), last_out);
        end
    end

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        do_reset();

        // R2 R4 R5 R6: varied pairs back to back and with gaps (R7)
        tag = "R4 R5 R6 value";
        send(1000, 2000);
        send(-1000, 2000);
        send(32767, -32768);
        send(-32768, -32768);
        for (int i = 0; i < 1500; i++) begin
            send(int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768);
            if (i % 5 == 0) idle(int'($urandom_range(1, 3)));
        end
        idle(8);
        check(exp_q.size() == 0, "R2 all results delivered", exp_q.size(), 0);

        // R1: reset in mid-run clears the filters (model restarts at zero)
        do_reset();

        // R3: settle DC at the positive limit, then jump to the negative one
        tag = "R3 saturation";
        for (int i = 0; i < 3000; i++) send(32767, 16384);
        for (int i = 0; i < 8; i++) send(-32768, 16384);
        idle(8);
        do_reset();

        // R8: DC on both channels settles to exactly zero
        tag = "R8 dc run";
        for (int i = 0; i < 40000; i++) send(1000, 20000);
        idle(8);
        check(pwr_out == '0, "R8 dc gives zero", longint'(pwr_out), 0);
        do_reset();

        // R9: in-phase sinusoids give positive power
        tag = "R9 in phase";
        for (int i = 0; i < 20000; i++) begin
            real ph;
            ph = 2.0 * 3.14159265358979 * real'(i % 64) / 64.0;
            send(int'(20000.0 * $sin(ph)), int'(25000.0 * $sin(ph)));
        end
        idle(8);
        check(pwr_out > 0, "R9 in phase positive", longint'(pwr_out), 1);
        do_reset();

        // R9: antiphase sinusoids give negative power
        tag = "R9 antiphase";
        for (int i = 0; i < 20000; i++) begin
            real ph;
            ph = 2.0 * 3.14159265358979 * real'(i % 64) / 64.0;
            send(int'(-20000.0 * $sin(ph)), int'(25000.0 * $sin(ph)));
        end
        idle(8);
        check(pwr_out < 0, "R9 antiphase negative", longint'(pwr_out), -1);

        idle(4);
        summary();
        $finish;
    end

endmodule